// File: doc/BRIEF.md
# PID-Gated Memory Region Guard

This block sits between a requester and two small on-chip memory regions and decides, access by access, whether the requester's process ID may touch the target. A request carries an address, a 3-bit process ID, a write flag and write data. The guard decodes the address into one of two 8 KB regions: a "fast" region that answers in two aliased address windows, or a "slow" region in a single window. It then looks up a per-process permission bit in the configuration register that belongs to that region. Process IDs 0 and 1 are privileged and bypass the lookup. Addresses that fall in neither region are passed on untouched and flagged as foreign.

The request side and the memory side form a valid/ready stream. A granted or foreign request is forwarded to the memory in the same cycle, and back-pressure from the memory (`mem_ready` low) stalls the requester through `req_ready`. A denied request is never forwarded. It completes at once, with `req_ready` high, `req_err` high and zero read data. The memory therefore sees neither a valid nor a write strobe for it, and its ready signal has no effect on it.

The two permission registers are themselves guarded. The slow-region register accepts writes only from process 0. The fast-region register accepts writes from process 0 or 1. Any other write is dropped and raises a one-cycle violation pulse.

Top module: `pidg_guard`

## Requirements
- R1: Addresses 0x3FF8_0000–0x3FF8_1FFF and 0x400C_0000–0x400C_1FFF decode to region code 1 (fast). Address 0x5000_0000–0x5000_1FFF decodes to region code 2 (slow). Any other address gives code 0. `mem_offset` equals address bits [12:0], so both fast windows reach the same offset.
- R2: A request from process 0 or 1 to either region is always granted: `req_err` stays low.
- R3: A request from process 2–7 to a region is granted exactly when bit [pid] of that region's permission register is 1. Register select 0 is the fast register and select 1 is the slow register.
- R4: After reset both permission registers hold 0, so every request from process 2–7 to either region is denied.
- R5: A denied request raises `req_err` in the same cycle. During that cycle `req_ready` is 1, `req_rdata` is 0, and `mem_valid` and `mem_we` are 0.
- R6: A granted request is forwarded in the same cycle. `mem_valid` follows `req_valid`, `mem_we` follows `req_we`, `req_ready` follows `mem_ready`, and `req_rdata` follows `mem_rdata`.
- R7: A request outside both regions is forwarded whatever the process ID. It raises `req_foreign`, drives region code 0, and never raises `req_err`.
- R8: A configuration write loads `cfg_wdata` into the selected register at the clock edge. The write takes effect only if the writer is process 0 for select 1, or process 0 or 1 for select 0. The new value governs requests from the next cycle on.
- R9: A configuration write without the needed privilege leaves both registers unchanged. It drives `cfg_viol` high for exactly the one cycle after that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 32 | Request byte address |
| req_pid | input | 3 | Requester process ID |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data (zero when denied) |
| req_err | output | 1 | Request denied |
| req_foreign | output | 1 | Request outside both guarded regions |
| mem_valid | output | 1 | Forwarded request valid |
| mem_ready | input | 1 | Memory accepts the forwarded request |
| mem_addr | output | 32 | Forwarded address |
| mem_region | output | 2 | Region code (0 none, 1 fast, 2 slow) |
| mem_offset | output | 13 | Offset within the region |
| mem_we | output | 1 | Forwarded write strobe |
| mem_wdata | output | 32 | Forwarded write data |
| mem_rdata | input | 32 | Memory read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = fast register, 1 = slow register |
| cfg_pid | input | 3 | Process ID of the configuration writer |
| cfg_wdata | input | 8 | Permission bits, bit n for process n |
| cfg_viol | output | 1 | One-cycle pulse after a refused configuration write |

## Verification
Random requests mix all eight process IDs with addresses inside the three windows, on the bytes just outside each window, and far away. This separates privileged bypass, table lookup and foreign pass-through, and it exposes an off-by-one in the decoder. Random permission patterns written through both registers, each by every process ID, show whether the per-register privilege levels differ as required and whether a refused write leaves the table unchanged. Random `mem_ready` and `mem_rdata` values show that back-pressure and read data reach the requester only for forwarded requests. Directed cases cover the reset state, offsets matching across the two aliased fast windows, and back-to-back refused writes.

// File: rtl/pidg_pkg.sv
package pidg_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_FAST = 2'd1,
    RGN_SLOW = 2'd2
  } rgn_e;

  localparam int NUM_WIN = 3;
  localparam int NUM_PREG = 2;

  function automatic logic rgn_to_sel(input rgn_e r);
    return (r == RGN_SLOW);
  endfunction
endpackage

// File: rtl/pidg_addr_decode.sv
module pidg_addr_decode
  import pidg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE = '0,
  parameter logic [NUM_WIN-1:0][1:0]        WIN_RGN  = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn,
  output logic [OFF_W-1:0]  offset
);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [NUM_WIN-1:0]      hit;
  logic [NUM_WIN-1:0][1:0] code_masked;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [TAG_W-1:0] TAG = WIN_BASE[w][ADDR_W-1:OFF_W];
    assign hit[w]         = (addr[ADDR_W-1:OFF_W] == TAG);
    assign code_masked[w] = hit[w] ? WIN_RGN[w] : 2'b00;
  end

  always_comb begin
    logic [1:0] acc;
    acc = 2'b00;
    for (int w = 0; w < NUM_WIN; w++) acc = acc | code_masked[w];
    rgn = rgn_e'(acc);
  end

  assign offset = addr[OFF_W-1:0];
endmodule

// File: rtl/pidg_perm_regs.sv
module pidg_perm_regs
  import pidg_pkg::*;
#(
  parameter int PID_W  = 3,
  parameter int PERM_W = 8,
  parameter logic [NUM_PREG-1:0][PID_W-1:0] WR_MAX_PID = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic                             cfg_sel,
  input  logic [PID_W-1:0]                 cfg_pid,
  input  logic [PERM_W-1:0]                cfg_wdata,
  output logic [NUM_PREG-1:0][PERM_W-1:0]  perm,
  output logic                             cfg_viol
);
  logic [NUM_PREG-1:0] sel_hot;
  logic [NUM_PREG-1:0] wr_ok;
  logic                refused;

  for (genvar r = 0; r < NUM_PREG; r++) begin : g_reg
    assign sel_hot[r] = cfg_we && (cfg_sel == r[0]);
    assign wr_ok[r]   = sel_hot[r] && (cfg_pid <= WR_MAX_PID[r]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        perm[r] <= '0;
      else if (wr_ok[r]) perm[r] <= cfg_wdata;
    end
  end

  assign refused = |(sel_hot & ~wr_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_viol <= 1'b0;
    else        cfg_viol <= refused;
  end
endmodule

// File: rtl/pidg_access_ctl.sv
module pidg_access_ctl
  import pidg_pkg::*;
#(
  parameter int PID_W        = 3,
  parameter int PERM_W       = 8,
  parameter int DATA_W       = 32,
  parameter int PRIV_MAX_PID = 1
) (
  input  rgn_e                            rgn,
  input  logic [PID_W-1:0]                pid,
  input  logic [NUM_PREG-1:0][PERM_W-1:0] perm,
  input  logic                            req_valid,
  input  logic                            req_we,
  input  logic                            mem_ready,
  input  logic [DATA_W-1:0]               mem_rdata,
  output logic                            req_ready,
  output logic [DATA_W-1:0]               req_rdata,
  output logic                            req_err,
  output logic                            req_foreign,
  output logic                            mem_valid,
  output logic                            mem_we
);
  logic guarded;
  logic privileged;
  logic table_bit;
  logic allowed;

  assign guarded    = (rgn != RGN_NONE);
  assign privileged = (int'(pid) <= PRIV_MAX_PID);
  assign table_bit  = perm[rgn_to_sel(rgn)][pid];
  assign allowed    = !guarded || privileged || table_bit;

  assign mem_valid   = req_valid && allowed;
  assign mem_we      = req_valid && allowed && req_we;
  assign req_err     = req_valid && !allowed;
  assign req_foreign = req_valid && !guarded;
  assign req_ready   = allowed ? mem_ready : 1'b1;
  assign req_rdata   = allowed ? mem_rdata : '0;
endmodule

// File: rtl/pidg_guard.sv
module pidg_guard
  import pidg_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int PID_W         = 3,
  parameter int REGION_BYTES  = 8192,
  parameter int PRIV_MAX_PID  = 1,
  parameter logic [ADDR_W-1:0] FAST_BASE_A = 32'h3FF8_0000,
  parameter logic [ADDR_W-1:0] FAST_BASE_B = 32'h400C_0000,
  parameter logic [ADDR_W-1:0] SLOW_BASE   = 32'h5000_0000,
  parameter int OFF_W  = $clog2(REGION_BYTES),
  parameter int PERM_W = 1 << PID_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [PID_W-1:0]    req_pid,
  input  logic                req_we,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   req_rdata,
  output logic                req_err,
  output logic                req_foreign,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [1:0]          mem_region,
  output logic [OFF_W-1:0]    mem_offset,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [PID_W-1:0]    cfg_pid,
  input  logic [PERM_W-1:0]   cfg_wdata,
  output logic                cfg_viol
);
  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] WIN_BASE =
    {SLOW_BASE, FAST_BASE_B, FAST_BASE_A};
  localparam logic [NUM_WIN-1:0][1:0] WIN_RGN =
    {RGN_SLOW, RGN_FAST, RGN_FAST};
  localparam logic [PID_W-1:0] FAST_WR_MAX = PID_W'(PRIV_MAX_PID);
  localparam logic [PID_W-1:0] SLOW_WR_MAX = '0;
  localparam logic [NUM_PREG-1:0][PID_W-1:0] WR_MAX_PID =
    {SLOW_WR_MAX, FAST_WR_MAX};

  rgn_e                            rgn;
  logic [NUM_PREG-1:0][PERM_W-1:0] perm;

  pidg_addr_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .WIN_BASE(WIN_BASE), .WIN_RGN(WIN_RGN)
  ) u_dec (
    .addr(req_addr), .rgn(rgn), .offset(mem_offset)
  );

  pidg_perm_regs #(
    .PID_W(PID_W), .PERM_W(PERM_W), .WR_MAX_PID(WR_MAX_PID)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_pid(cfg_pid),
    .cfg_wdata(cfg_wdata), .perm(perm), .cfg_viol(cfg_viol)
  );

  pidg_access_ctl #(
    .PID_W(PID_W), .PERM_W(PERM_W), .DATA_W(DATA_W),
    .PRIV_MAX_PID(PRIV_MAX_PID)
  ) u_ctl (
    .rgn(rgn), .pid(req_pid), .perm(perm),
    .req_valid(req_valid), .req_we(req_we),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .req_ready(req_ready), .req_rdata(req_rdata),
    .req_err(req_err), .req_foreign(req_foreign),
    .mem_valid(mem_valid), .mem_we(mem_we)
  );

  assign mem_addr   = req_addr;
  assign mem_wdata  = req_wdata;
  assign mem_region = rgn;
endmodule

// File: rtl/pidg_guard_chk.sv
module pidg_guard_chk #(
  parameter int DATA_W = 32,
  parameter int PID_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PID_W-1:0]  req_pid,
  input logic              req_we,
  input logic [DATA_W-1:0] req_rdata,
  input logic              req_err,
  input logic              req_foreign,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [1:0]        mem_region,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              cfg_we,
  input logic              cfg_viol
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_PRIV_NEVER_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_pid <= 3'd1) |-> !req_err); // R2

  AST_DENY_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!mem_valid && !mem_we && req_ready && req_rdata == '0)); // R5

  AST_GRANT_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_err) |-> (mem_valid && req_ready == mem_ready
                                 && req_rdata == mem_rdata && mem_we == req_we)); // R6

  AST_FOREIGN_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_foreign |-> (!req_err && mem_region == 2'd0 && mem_valid)); // R7

  AST_VIOL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(cfg_we)) |-> !cfg_viol); // R9
endmodule

bind pidg_guard pidg_guard_chk #(.DATA_W(DATA_W), .PID_W(PID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_pid(req_pid), .req_we(req_we), .req_rdata(req_rdata),
  .req_err(req_err), .req_foreign(req_foreign), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_region(mem_region), .mem_we(mem_we),
  .mem_rdata(mem_rdata), .cfg_we(cfg_we), .cfg_viol(cfg_viol)
);

// File: tb/pidg_guard_test.sv
module pidg_guard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic [2:0]  req_pid = '0, cfg_pid = '0;
  logic        mem_ready = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_ready, req_err, req_foreign, mem_valid, mem_we, cfg_viol;
  logic [31:0] req_rdata, mem_addr, mem_wdata;
  logic [1:0]  mem_region;
  logic [12:0] mem_offset;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m_perm [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pidg_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_pid(req_pid), .req_we(req_we),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .req_err(req_err),
    .req_foreign(req_foreign), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_region(mem_region), .mem_offset(mem_offset),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_pid(cfg_pid),
    .cfg_wdata(cfg_wdata), .cfg_viol(cfg_viol)
  );

  function automatic logic [1:0] exp_rgn(input logic [31:0] a);
    if (a >= 32'h3FF8_0000 && a <= 32'h3FF8_1FFF) return 2'd1;
    if (a >= 32'h400C_0000 && a <= 32'h400C_1FFF) return 2'd1;
    if (a >= 32'h5000_0000 && a <= 32'h5000_1FFF) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic exp_allow(input logic [31:0] a, input logic [2:0] p);
    logic [1:0] r;
    r = exp_rgn(a);
    if (r == 2'd0) return 1'b1;
    if (p <= 3'd1) return 1'b1;
    return m_perm[r == 2'd2 ? 1 : 0][p];
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drives one request after a falling edge and checks all combinational outputs.
  task automatic access(input logic [31:0] a, input logic [2:0] p, input logic we,
                        input logic rdy, input logic [31:0] rd);
    logic al;
    logic [1:0] r;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_pid = p; req_we = we;
    req_wdata = $urandom; mem_ready = rdy; mem_rdata = rd;
    #1;
    al = exp_allow(a, p);
    r  = exp_rgn(a);
    check(mem_region == r, "R1 region", 64'(mem_region), 64'(r));
    check(mem_offset == a[12:0], "R1 offset", 64'(mem_offset), 64'(a[12:0]));
    check(req_err == !al, "R3 err", 64'(req_err), 64'(!al));
    check(req_foreign == (r == 2'd0), "R7 foreign", 64'(req_foreign), 64'(r == 2'd0));
    if (al) begin
      check(mem_valid && mem_we == we && req_ready == rdy && req_rdata == rd,
            "R6 forward", {mem_valid, mem_we, req_ready, req_rdata},
            {1'b1, we, rdy, rd});
    end else begin
      check(!mem_valid && !mem_we && req_ready && req_rdata == 0,
            "R5 deny", {mem_valid, mem_we, req_ready, req_rdata},
            {1'b0, 1'b0, 1'b1, 32'h0});
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic s, input logic [2:0] p, input logic [7:0] d);
    logic ok;
    ok = (p == 3'd0) || (s == 1'b0 && p == 3'd1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_pid = p; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (ok) m_perm[s] = d;
    check(cfg_viol == !ok, ok ? "R8 accepted write" : "R9 viol pulse",
          64'(cfg_viol), 64'(!ok));
    @(posedge clk); #1;
    check(cfg_viol == 1'b0, "R9 one-cycle pulse", 64'(cfg_viol), 64'h0);
  endtask

  function automatic logic [31:0] rand_addr();
    logic [31:0] base;
    logic [31:0] k;
    k = $urandom_range(0, 5);
    case (k)
      0: base = 32'h3FF8_0000;
      1: base = 32'h400C_0000;
      2: base = 32'h5000_0000;
      default: return $urandom;
    endcase
    k = $urandom_range(0, 9);
    if (k == 0) return base - 1;
    if (k == 1) return base + 32'h2000;
    return base + {19'h0, 13'($urandom)};
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'h1D2C_0A05);
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_perm[0] = 8'h00; m_perm[1] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 check(cfg_viol == 1'b0, "R9 reset", 64'(cfg_viol), 64'h0);

    // R4: reset denies process 2..7 everywhere
    for (int p = 2; p < 8; p++) begin
      access(32'h3FF8_0010, 3'(p), 1'b0, 1'b1, 32'hA5A5_0000);
      access(32'h5000_1FFF, 3'(p), 1'b1, 1'b1, 32'h1234_5678);
    end
    // R2: privileged processes always pass
    access(32'h400C_1FFC, 3'd0, 1'b1, 1'b0, 32'h1);
    access(32'h5000_0000, 3'd1, 1'b0, 1'b1, 32'hDEAD_BEEF);
    // R1: both fast windows give the same offset
    access(32'h3FF8_0345, 3'd0, 1'b0, 1'b1, 32'h7);
    access(32'h400C_0345, 3'd0, 1'b0, 1'b1, 32'h7);
    // R7: window edges are foreign
    access(32'h3FF7_FFFF, 3'd5, 1'b1, 1'b1, 32'h9);
    access(32'h5000_2000, 3'd7, 1'b0, 1'b0, 32'h9);

    // R8: PID 1 writes fast, refused on slow; R9 back-to-back refusals
    cfg_write(1'b0, 3'd1, 8'b0000_0100);
    access(32'h3FF8_0100, 3'd2, 1'b0, 1'b1, 32'h55);
    access(32'h5000_0100, 3'd2, 1'b0, 1'b1, 32'h55);
    cfg_write(1'b1, 3'd1, 8'hFF);
    cfg_write(1'b1, 3'd4, 8'hFF);
    access(32'h5000_0100, 3'd4, 1'b0, 1'b1, 32'h66);
    cfg_write(1'b1, 3'd0, 8'b1000_0000);
    access(32'h5000_0100, 3'd7, 1'b1, 1'b1, 32'h77);
    access(32'h3FF8_0100, 3'd7, 1'b1, 1'b1, 32'h77);

    // Random mix of configuration writes and requests
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0)
        cfg_write(1'($urandom), 3'($urandom), 8'($urandom));
      else
        access(rand_addr(), 3'($urandom), 1'($urandom), 1'($urandom), $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule